// File: doc/BRIEF.md
# Dual-Mode Service Watchdog

This block supervises a processor by watching a service line for falling edges. A free-running cycle counter restarts on every valid falling edge. If the count reaches the active timeout before the next edge, the block raises a one-cycle fault request. A downstream reset stretcher turns that request into a reset pulse.

The timeout comes from a programmable base cycle count. A mode-select line picks between two timeouts. In normal mode the timeout is the base count. In extended mode it is the base count times 128. Any change of the mode-select line restarts the timer. A base count of zero switches the watchdog off.

The system reset is an input. While it is asserted, the timer is held at zero and no fault can be raised. Both the service line and the mode line are asynchronous. Each passes through its own two-flop synchroniser, and edges are detected on the synchronised values.

Top module: `wdt_dual_mode`

## Requirements
- R1: While `rst_n` is low, `fault_o` is 0 and the timer is held at zero. The timer starts counting at the first clock edge after release, so with the service line steady high, the first fault appears at the L-th rising edge after the last edge at which `rst_n` was sampled low, where L is the active timeout.
- R2: `svc_i` and `ext_mode_i` each pass through two synchroniser flops and one edge-detect flop. A change sampled at clock edge e acts at edge e+2: it clears the timer there, and a mode change also switches the timeout there. The synchroniser flops reset to 1 for `svc_i` and to 0 for `ext_mode_i`.
- R3: A falling edge (1 to 0) of the synchronised service line clears the timer. A rising edge has no effect: after a fall whose clear lands at edge c, with a rise in between, the fault still appears at edge c+L.
- R4: In normal mode (`ext_mode_i` = 0), the active timeout L equals `base_timeout_i`. Without service, faults recur every L cycles.
- R5: In extended mode (`ext_mode_i` = 1), the active timeout L equals `base_timeout_i` × 128.
- R6: Any transition of the synchronised mode line clears the timer, whether it goes 0 to 1 or 1 to 0.
- R7: When `base_timeout_i` = 0, `fault_o` stays 0 and the timer is held at zero. After a nonzero base is applied, the first fault comes L edges later.
- R8: `fault_o` is a one-cycle strobe whenever L > 1. The timer restarts from zero in the cycle the fault fires, so the next fault follows exactly L cycles later.
- R9: The counter holds `base_timeout_i` × 128 without overflow. An extended timeout longer than 2^BASE_W cycles expires at exactly L cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset; holds the timer clear |
| svc_i | input | 1 | Asynchronous service line; a falling edge restarts the timer |
| ext_mode_i | input | 1 | Asynchronous mode select: 0 normal, 1 extended (×128) |
| base_timeout_i | input | BASE_W | Base timeout in clock cycles; 0 disables the watchdog |
| fault_o | output | 1 | One-cycle fault request to the reset stretcher |

## Verification
The assertions take `base_timeout_i` to be quasi-static. The overflow property is therefore relaxed in any cycle where the limit has just moved. The strobe property assumes the timeout is longer than one cycle. The stimulus changes the base count only while reset is asserted, in the cycle right after a fault, or while the watchdog is disabled. It drives the asynchronous lines away from the active clock edge. The random rounds keep the base between 1 and 40 and toggle the service and mode lines at random, so both clears and expiries occur often. Directed cases cover the exact expiry cycle in each mode, a rising edge alone, both directions of mode change, the disabled state, and an extended timeout wider than the base field.

// File: rtl/wdt_pkg.sv
// Shared constants and types for the dual-mode watchdog.
// Assumes: the extended multiplier is a power of two, applied as a shift.
package wdt_pkg;
    localparam int unsigned WDT_EXT_SHIFT = 7;   // extended mode multiplies the base by 2**7 = 128

    typedef enum logic {
        WDT_MODE_NORMAL   = 1'b0,
        WDT_MODE_EXTENDED = 1'b1
    } wdt_mode_e;
endpackage

// File: rtl/wdt_sync_chain.sv
// Multi-flop synchroniser with one extra delayed copy for edge detection.
// Assumes: STAGES >= 2; async_i may change at any time relative to clk.
module wdt_sync_chain #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o,
    output logic prev_o
);
    logic [STAGES-1:0] chain;
    logic              prev_q;

    // Shift the asynchronous level through the synchroniser flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain[0] <= async_i;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    // Keep the previous synchronised level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= chain[STAGES-1];
    end

    assign sync_o = chain[STAGES-1];
    assign prev_o = prev_q;
endmodule

// File: rtl/wdt_limit_sel.sv
// Forms the active timeout from the base count and the synchronised mode.
// Assumes: output width is BASE_W + WDT_EXT_SHIFT so the shifted base never truncates.
module wdt_limit_sel
    import wdt_pkg::*;
#(
    parameter int unsigned BASE_W = 16,
    localparam int unsigned CNT_W = BASE_W + WDT_EXT_SHIFT
) (
    input  logic [BASE_W-1:0] base_i,
    input  wdt_mode_e         mode_i,
    output logic [CNT_W-1:0]  limit_o,
    output logic              enable_o
);
    logic [CNT_W-1:0] base_wide;

    // Zero-extend the base, then shift it left in extended mode.
    always_comb begin
        base_wide = {{WDT_EXT_SHIFT{1'b0}}, base_i};
        if (mode_i == WDT_MODE_EXTENDED) limit_o = base_wide << WDT_EXT_SHIFT;
        else                             limit_o = base_wide;
        enable_o = |base_i;
    end
endmodule

// File: rtl/wdt_tick_counter.sv
// Cycle counter that raises a one-cycle expiry strobe on reaching the limit.
// Assumes: limit_i is nonzero whenever enable_i is high; clear_i wins over expiry.
module wdt_tick_counter #(
    parameter int unsigned CNT_W = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             enable_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             expire_q;

    // Count cycles since the last clear; wrap to zero and strobe on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i || !enable_i) begin
            cnt_q    <= '0;
            expire_q <= 1'b0;
        end else if (cnt_q >= limit_i - ONE) begin
            cnt_q    <= '0;
            expire_q <= 1'b1;
        end else begin
            cnt_q    <= cnt_q + ONE;
            expire_q <= 1'b0;
        end
    end

    assign cnt_o    = cnt_q;
    assign expire_o = expire_q;
endmodule

// File: rtl/wdt_dual_mode.sv
// Dual-mode watchdog: restarts on service-line falling edges or mode changes,
// and raises a one-cycle fault when the active timeout elapses.
// Assumes: base_timeout_i is quasi-static; svc_i and ext_mode_i are asynchronous.
module wdt_dual_mode
    import wdt_pkg::*;
#(
    parameter int unsigned BASE_W      = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              svc_i,
    input  logic              ext_mode_i,
    input  logic [BASE_W-1:0] base_timeout_i,
    output logic              fault_o
);
    localparam int unsigned CNT_W = BASE_W + WDT_EXT_SHIFT;

    logic             svc_sync, svc_prev, mode_sync, mode_prev;
    logic             svc_fall, mode_flip, timer_clear, wd_enable;
    logic [CNT_W-1:0] limit, cnt;
    wdt_mode_e        mode_cur;

    wdt_sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_svc_sync (
        .clk(clk), .rst_n(rst_n), .async_i(svc_i),
        .sync_o(svc_sync), .prev_o(svc_prev)
    );

    wdt_sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_mode_sync (
        .clk(clk), .rst_n(rst_n), .async_i(ext_mode_i),
        .sync_o(mode_sync), .prev_o(mode_prev)
    );

    // Derive the restart events from the synchronised levels.
    always_comb begin
        svc_fall    = svc_prev & ~svc_sync;
        mode_flip   = mode_prev ^ mode_sync;
        timer_clear = svc_fall | mode_flip;
        mode_cur    = wdt_mode_e'(mode_sync);
    end

    wdt_limit_sel #(.BASE_W(BASE_W)) u_limit (
        .base_i(base_timeout_i), .mode_i(mode_cur),
        .limit_o(limit), .enable_o(wd_enable)
    );

    wdt_tick_counter #(.CNT_W(CNT_W)) u_counter (
        .clk(clk), .rst_n(rst_n), .clear_i(timer_clear), .enable_i(wd_enable),
        .limit_i(limit), .cnt_o(cnt), .expire_o(fault_o)
    );
endmodule

// File: rtl/wdt_dual_mode_chk.sv
// Property checker for the dual-mode watchdog, bound to its top module.
// Assumes: base_timeout_i moves only while the counter is reset, cleared or disabled.
module wdt_dual_mode_chk #(
    parameter int unsigned BASE_W = 16,
    parameter int unsigned CNT_W  = 23
) (
    input logic              clk,
    input logic              rst_n,
    input logic [BASE_W-1:0] base_timeout_i,
    input logic              fault_o,
    input logic              svc_fall,
    input logic              mode_flip,
    input logic              timer_clear,
    input logic              wd_enable,
    input logic [CNT_W-1:0]  limit,
    input logic [CNT_W-1:0]  cnt
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (!fault_o && cnt == '0));

    // R3
    fall_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_fall |=> (cnt == '0 && !fault_o));

    // R6
    flip_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_flip |=> (cnt == '0 && !fault_o));

    // R7
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (base_timeout_i == '0) |=> !fault_o);

    // R8
    strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && limit > CNT_W'(1)) |=> !fault_o);

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> cnt == '0);

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_enable && !timer_clear && cnt < limit - CNT_W'(1)) |=> cnt == $past(cnt) + CNT_W'(1));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_enable && $stable(limit)) |-> cnt < limit);
endmodule

bind wdt_dual_mode wdt_dual_mode_chk #(.BASE_W(BASE_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .base_timeout_i(base_timeout_i), .fault_o(fault_o),
    .svc_fall(svc_fall), .mode_flip(mode_flip), .timer_clear(timer_clear),
    .wd_enable(wd_enable), .limit(limit), .cnt(cnt)
);

// File: tb/wdt_dual_mode_tb.sv
module wdt_dual_mode_tb;
    localparam int BASE_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              svc_i = 1'b1;
    logic              ext_mode_i = 1'b0;
    logic [BASE_W-1:0] base_timeout_i = 16'd5;
    logic              fault_o;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    bit    cmp_en = 1'b0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    wdt_dual_mode #(.BASE_W(BASE_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .svc_i(svc_i), .ext_mode_i(ext_mode_i),
        .base_timeout_i(base_timeout_i), .fault_o(fault_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Timeout from the requirements: base, times 128 in extended mode (R4, R5).
    function automatic longint active_limit(input longint base, input bit ext);
        return ext ? base * 128 : base;
    endfunction

    // Cycle model built from R1..R9: inputs sampled at edge e act at edge e+2.
    longint m_cnt = 0;
    bit     m_fault = 1'b0;
    bit     h1s = 1, h2s = 1, h3s = 1, h1m = 0, h2m = 0, h3m = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_fault = 0;
            h1s = 1; h2s = 1; h3s = 1; h1m = 0; h2m = 0; h3m = 0;
        end else begin
            bit     clr;
            longint lim;
            clr = (h3s && !h2s) || (h3m != h2m);
            lim = active_limit(longint'(base_timeout_i), h2m);
            if (clr || base_timeout_i == 0) begin
                m_cnt = 0; m_fault = 0;
            end else if (m_cnt >= lim - 1) begin
                m_cnt = 0; m_fault = 1;
            end else begin
                m_cnt++; m_fault = 0;
            end
            h3s = h2s; h2s = h1s; h1s = svc_i;
            h3m = h2m; h2m = h1m; h1m = ext_mode_i;
        end
    end

    always @(negedge clk) begin
        if (cmp_en && !done)
            check(fault_o == m_fault, cur_req, "fault_o vs model", fault_o, m_fault);
    end

    // Count edges until fault_o is seen high, sampling at the falling edge.
    task automatic measure(output int n);
        n = 0;
        do begin
            @(posedge clk); @(negedge clk); n++;
        end while (!fault_o && n < 100000);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        int n, faults;
        void'($urandom(32'h5EED_1234));

        // R1: reset holds the block quiet
        cur_req = "R1";
        cmp_en = 1'b1;
        faults = 0;
        repeat (20) begin
            @(negedge clk);
            if (fault_o) faults++;
        end
        check(faults == 0, "R1", "faults during reset", faults, 0);

        // R1 / R4: first fault exactly base edges after release
        rst_n = 1'b1;
        cur_req = "R4";
        measure(n);
        check(n == 5, "R1", "edges from release to first fault", n, 5);
        check(n == active_limit(5, 0), "R4", "normal timeout", n, 5);

        // R8: next fault exactly L later, and strobe lasts one cycle
        cur_req = "R8";
        measure(n);
        check(n == 5, "R8", "fault-to-fault period", n, 5);
        @(posedge clk); @(negedge clk);
        check(fault_o == 1'b0, "R8", "strobe width", fault_o, 0);
        measure(n);

        // R3: regular servicing prevents any fault
        cur_req = "R3";
        base_timeout_i = 16'd10;
        faults = 0;
        for (int i = 0; i < 30; i++) begin
            svc_i = 1'b0;
            repeat (2) begin @(negedge clk); if (fault_o) faults++; end
            svc_i = 1'b1;
            repeat (2) begin @(negedge clk); if (fault_o) faults++; end
        end
        check(faults == 0, "R3", "faults while serviced", faults, 0);

        // R3: a rising edge after a fall does not restart the timer
        svc_i = 1'b0;
        n = 0;
        do begin
            @(posedge clk); @(negedge clk); n++;
            if (n == 5) svc_i = 1'b1;
        end while (!fault_o && n < 1000);
        check(n == 10 + 3, "R3", "rise ignored, fault after fall", n, 13);

        // R5: extended mode multiplies base by 128 (mode change restarts too)
        cur_req = "R5";
        base_timeout_i = 16'd3;
        ext_mode_i = 1'b1;
        measure(n);
        check(n == active_limit(3, 1) + 3, "R5", "extended timeout", n, 387);

        // R6: mode change 1->0 and 0->1 each clear the timer
        cur_req = "R6";
        ext_mode_i = 1'b0;
        measure(n);
        check(n == active_limit(3, 0) + 3, "R6", "clear on 1->0 change", n, 6);
        ext_mode_i = 1'b1;
        measure(n);
        check(n == active_limit(3, 1) + 3, "R6", "clear on 0->1 change", n, 387);

        // R7: zero base disables; enabling later starts from zero
        cur_req = "R7";
        base_timeout_i = '0;
        faults = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (fault_o) faults++;
            if ($urandom_range(7) == 0)  svc_i = ~svc_i;
            if ($urandom_range(31) == 0) ext_mode_i = ~ext_mode_i;
        end
        check(faults == 0, "R7", "faults while disabled", faults, 0);
        svc_i = 1'b1;
        ext_mode_i = 1'b0;
        repeat (6) @(negedge clk);
        check(fault_o == 1'b0, "R7", "still quiet after settle", fault_o, 0);
        base_timeout_i = 16'd7;
        measure(n);
        check(n == 7, "R7", "first fault after enable", n, 7);

        // R9: extended timeout beyond the base field width
        cur_req = "R9";
        base_timeout_i = 16'd600;
        ext_mode_i = 1'b1;
        measure(n);
        check(n == active_limit(600, 1) + 3, "R9", "wide extended timeout", n, 76803);

        // R2: random rounds against the cycle model
        cur_req = "R2";
        for (int r = 0; r < 20; r++) begin
            @(negedge clk);
            rst_n = 1'b0;
            base_timeout_i = BASE_W'($urandom_range(40, 1));
            ext_mode_i = 1'($urandom_range(1));
            svc_i = 1'($urandom_range(1));
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            for (int c = 0; c < 400; c++) begin
                @(negedge clk);
                if ($urandom_range(7) == 0)  svc_i = ~svc_i;
                if ($urandom_range(63) == 0) ext_mode_i = ~ext_mode_i;
            end
        end

        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule